// File: doc/BRIEF.md
# Segmented Multichannel Scan Sequencer

This block drives the channel select of an analog multiplexer that feeds an integrating converter with a fixed conversion time. Each converter window covers only a fraction of one noise period. The noise integral for a channel is therefore built up over X visits, where X is odd. Between two visits to the same channel the converter runs exactly L conversions. L is chosen as one more than a multiple of X, so each visit to a channel picks up the noise waveform where that channel's previous window ended. The X segments then join into whole noise periods, and the noise cancels in the sum.

The block takes the channel count N and the segment count X as plain inputs. It moves the select on every conversion-done strobe and adds each signed result into the accumulator of the channel that produced it. When a channel has collected X results, the block publishes their sum on that channel's readout lane and sets the channel's valid flag. The converter and the multiplexer are outside the block.

Top module: `seg_scan_seq`

## Requirements
- R1: After a synchronous active-high reset, `mux_sel` is 0, every bit of `sum_valid` is 0 and every readout lane is 0.
- R2: The effective segment count Xe is `cfg_segs` with bit 0 forced to 1, so 0 becomes 1, 2 becomes 3, 4 becomes 5 and 6 becomes 7. The effective channel count Ne is `cfg_nch`, with 0 read as 1 and any value above MAX_CH read as MAX_CH. The scan length L is floor(Ne/Xe)*Xe + 1; when that value exceeds Ne, Xe is subtracted from it. For example, 16 channels with Xe=3 give L=16, and 15 channels with Xe=3 give L=13. `mux_sel` always stays within 0 to L-1.
- R3: Each `conv_done` pulse advances `mux_sel` by one, and the select goes from L-1 back to 0. In a cycle without a pulse, `mux_sel` holds its value.
- R4: A `conv_done` pulse adds the signed `conv_data` into the accumulator of the channel that `mux_sel` selected in that cycle, before the select advances. No other channel's state changes.
- R5: On the Xe-th pulse for a channel, counted since that channel last completed or since the last flush, the channel's readout lane takes the sum of those Xe results and its `sum_valid` bit goes to 1. The accumulator then starts again from zero. The lane value and the flag hold until the channel completes again. Channel c is carried on `sum_flat[c*ACC_W +: ACC_W]` and on `sum_valid[c]`.
- R6: In any cycle where `cfg_nch` or `cfg_segs` differs from its value in the previous cycle, the block discards that cycle's pulse. It clears every accumulator, segment count, readout lane and valid flag, and `mux_sel` becomes 0.
- R7: Results and sums are two's complement. A negative result lowers the sum, and each readout lane is a signed ACC_W-bit value that Xe full-scale results of either sign cannot overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nch | input | 5 | Number of available channels N |
| cfg_segs | input | 3 | Segment count X (forced odd) |
| conv_done | input | 1 | One pulse per finished conversion |
| conv_data | input | 14 | Signed result of that conversion |
| mux_sel | output | 4 | Multiplexer channel select |
| sum_flat | output | 272 | Signed readout lanes, ACC_W=17 bits per channel, channel 0 in the low bits |
| sum_valid | output | 16 | Per-channel flag for a completed sum |

## Verification
A wrong scan length or a wrong wrap point shows on `mux_sel` at the first pulse that should wrap, which comes at most L pulses after a flush. A conversion added to the wrong channel shows on a readout lane when that channel next completes, at most Xe*L pulses later. A segment count that is off by one shows the same way, as a flag that rises early or late. A flush that misses some state shows on the next cycle as a nonzero lane, a set flag or a nonzero select. The reference model is compared with every output on every clock, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    // Action applied to one channel lane in a cycle.
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_ACCUM = 2'd1,
        EV_CLOSE = 2'd2,
        EV_FLUSH = 2'd3
    } lane_ev_e;

    // Scan length: the largest value of the form k*x+1 that does not exceed
    // the clamped channel count. The caller passes x already odd and nonzero.
    function automatic int unsigned scan_len(input int unsigned n,
                                             input int unsigned x,
                                             input int unsigned cap);
        int unsigned nn;
        nn = (n == 0) ? 1 : ((n > cap) ? cap : n);
        return ((nn - 1) / x) * x + 1;
    endfunction

endpackage

// File: rtl/seg_scan_cfg.sv
module seg_scan_cfg #(
    parameter int MAX_CH = 16,
    parameter int CH_W   = 5,
    parameter int SEG_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CH_W-1:0]  cfg_nch,
    input  logic [SEG_W-1:0] cfg_segs,
    output logic [SEG_W-1:0] seg_eff,
    output logic [CH_W-1:0]  len,
    output logic             flush
);
    import seg_scan_pkg::*;

    logic [CH_W-1:0]  nch_q;
    logic [SEG_W-1:0] segs_q;

    // The shadow copies load during reset as well, so leaving reset causes no flush.
    always_ff @(posedge clk) begin
        nch_q  <= cfg_nch;
        segs_q <= cfg_segs;
    end

    assign seg_eff = cfg_segs | SEG_W'(1);
    assign len     = CH_W'(scan_len(int'(cfg_nch), int'(seg_eff), MAX_CH));
    assign flush   = (cfg_nch != nch_q) || (cfg_segs != segs_q);

    // R2: the scan length is never zero and never exceeds the channel limit
    a_r2_len_bounds: assert property (@(posedge clk) disable iff (rst)
        (len != '0) && (int'(len) <= MAX_CH));

    // R2: the effective segment count is always odd
    a_r2_seg_odd: assert property (@(posedge clk) disable iff (rst)
        seg_eff[0]);

endmodule

// File: rtl/seg_scan_ptr.sv
module seg_scan_ptr #(
    parameter int SEL_W = 4,
    parameter int CH_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             step,
    input  logic [CH_W-1:0]  len,
    output logic [SEL_W-1:0] sel
);
    logic last;

    assign last = (CH_W'(sel) == len - CH_W'(1));

    always_ff @(posedge clk) begin
        if (rst || flush)
            sel <= '0;
        else if (step)
            sel <= last ? '0 : sel + SEL_W'(1);
    end

    // R2: the select stays inside the scan
    a_r2_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        !flush |-> (CH_W'(sel) < len));

    // R3: a pulse at the last scanned channel returns the select to 0
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !flush && last) |=> (sel == '0));

    // R3: with no pulse the select holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !flush) |=> $stable(sel));

    // R6: a configuration change restarts the scan
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        flush |=> (sel == '0));

endmodule

// File: rtl/seg_scan_lane.sv
module seg_scan_lane #(
    parameter int DATA_W = 14,
    parameter int ACC_W  = 17,
    parameter int SEG_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     hit,
    input  logic signed [DATA_W-1:0] data,
    input  logic [SEG_W-1:0]         seg_eff,
    output logic signed [ACC_W-1:0]  sum,
    output logic                     valid
);
    import seg_scan_pkg::*;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] ext;
    logic [SEG_W-1:0]        cnt;
    lane_ev_e                ev;

    assign ext = {{(ACC_W-DATA_W){data[DATA_W-1]}}, data};

    always_comb begin
        if (flush)
            ev = EV_FLUSH;
        else if (hit)
            ev = (cnt == seg_eff - SEG_W'(1)) ? EV_CLOSE : EV_ACCUM;
        else
            ev = EV_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst || ev == EV_FLUSH) begin
            acc   <= '0;
            cnt   <= '0;
            sum   <= '0;
            valid <= 1'b0;
        end else begin
            case (ev)
                EV_ACCUM: begin
                    acc <= acc + ext;
                    cnt <= cnt + SEG_W'(1);
                end
                EV_CLOSE: begin
                    sum   <= acc + ext;
                    valid <= 1'b1;
                    acc   <= '0;
                    cnt   <= '0;
                end
                default: ;
            endcase
        end
    end

    // R5: the segment count stays below the effective segment count
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        !flush |-> (cnt < seg_eff));

    // R5: a completion sets the flag and restarts the accumulator
    a_r5_close: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_CLOSE) |=> (valid && acc == '0 && cnt == '0));

    // R4: a lane that is not hit keeps its state
    a_r4_untouched: assert property (@(posedge clk) disable iff (rst)
        (!hit && !flush) |=> ($stable(acc) && $stable(sum) && $stable(valid)));

    // R6: a flush clears the lane
    a_r6_flush: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!valid && acc == '0 && sum == '0));

endmodule

// File: rtl/seg_scan_seq.sv
module seg_scan_seq #(
    parameter int MAX_CH = 16,
    parameter int MAX_X  = 7,
    parameter int DATA_W = 14,
    parameter int CH_W   = $clog2(MAX_CH + 1),
    parameter int SEG_W  = $clog2(MAX_X + 1),
    parameter int SEL_W  = $clog2(MAX_CH),
    parameter int ACC_W  = DATA_W + SEG_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CH_W-1:0]           cfg_nch,
    input  logic [SEG_W-1:0]          cfg_segs,
    input  logic                      conv_done,
    input  logic signed [DATA_W-1:0]  conv_data,
    output logic [SEL_W-1:0]          mux_sel,
    output logic [MAX_CH*ACC_W-1:0]   sum_flat,
    output logic [MAX_CH-1:0]         sum_valid
);
    logic [SEG_W-1:0]  seg_eff;
    logic [CH_W-1:0]   len;
    logic              flush;
    logic [MAX_CH-1:0] hit;

    seg_scan_cfg #(.MAX_CH(MAX_CH), .CH_W(CH_W), .SEG_W(SEG_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_nch  (cfg_nch),
        .cfg_segs (cfg_segs),
        .seg_eff  (seg_eff),
        .len      (len),
        .flush    (flush)
    );

    seg_scan_ptr #(.SEL_W(SEL_W), .CH_W(CH_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .step  (conv_done),
        .len   (len),
        .sel   (mux_sel)
    );

    for (genvar c = 0; c < MAX_CH; c++) begin : g_lane
        assign hit[c] = conv_done && !flush && (mux_sel == SEL_W'(c));

        seg_scan_lane #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SEG_W(SEG_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .hit     (hit[c]),
            .data    (conv_data),
            .seg_eff (seg_eff),
            .sum     (sum_flat[c*ACC_W +: ACC_W]),
            .valid   (sum_valid[c])
        );
    end

    // R4: one conversion reaches at most one lane
    a_r4_one_lane: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    // R6: a pulse in a change cycle reaches no lane
    a_r6_drop: assert property (@(posedge clk) disable iff (rst)
        flush |-> (hit == '0));

endmodule

// File: tb/tb_seg_scan_seq.sv
module tb_seg_scan_seq;
    localparam int MAX_CH = 16;
    localparam int DATA_W = 14;
    localparam int ACC_W  = 17;

    logic              clk = 1'b0;
    logic              rst;
    logic [4:0]        cfg_nch;
    logic [2:0]        cfg_segs;
    logic              conv_done;
    logic signed [DATA_W-1:0] conv_data;
    logic [3:0]        mux_sel;
    logic [MAX_CH*ACC_W-1:0] sum_flat;
    logic [MAX_CH-1:0] sum_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_en = 0;
    logic [31:0] seed = 32'h1234_5678;

    // Reference model state
    int m_acc [MAX_CH];
    int m_seg [MAX_CH];
    int m_res [MAX_CH];
    bit m_val [MAX_CH];
    int m_sel;
    int m_pn, m_px;

    always #5 clk = ~clk;

    seg_scan_seq dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_nch   (cfg_nch),
        .cfg_segs  (cfg_segs),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .mux_sel   (mux_sel),
        .sum_flat  (sum_flat),
        .sum_valid (sum_valid)
    );

    function automatic int exp_len(int n, int x);
        int xe;
        int nn;
        int l;
        xe = x | 1;
        nn = n;
        if (nn < 1) nn = 1;
        if (nn > MAX_CH) nn = MAX_CH;
        l = (nn / xe) * xe + 1;
        if (l > nn) l = l - xe;
        return l;
    endfunction

    function automatic int lane(int c);
        logic signed [ACC_W-1:0] v;
        v = sum_flat[c*ACC_W +: ACC_W];
        return int'(v);
    endfunction

    task automatic model_clear();
        for (int c = 0; c < MAX_CH; c++) begin
            m_acc[c] = 0; m_seg[c] = 0; m_res[c] = 0; m_val[c] = 0;
        end
        m_sel = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_clear();
            m_pn = int'(cfg_nch);
            m_px = int'(cfg_segs);
        end else if (int'(cfg_nch) != m_pn || int'(cfg_segs) != m_px) begin
            model_clear();
            m_pn = int'(cfg_nch);
            m_px = int'(cfg_segs);
        end else if (conv_done) begin
            m_acc[m_sel] += int'(conv_data);
            m_seg[m_sel] += 1;
            if (m_seg[m_sel] == (m_px | 1)) begin
                m_res[m_sel] = m_acc[m_sel];
                m_val[m_sel] = 1;
                m_acc[m_sel] = 0;
                m_seg[m_sel] = 0;
            end
            m_sel = (m_sel + 1 >= exp_len(m_pn, m_px)) ? 0 : m_sel + 1;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(int'(mux_sel) == m_sel, "R3 select vs model", int'(mux_sel), m_sel);
            for (int c = 0; c < MAX_CH; c++) begin
                chk(sum_valid[c] == m_val[c], "R5 valid flag vs model",
                    int'(sum_valid[c]), int'(m_val[c]));
                chk(lane(c) == m_res[c], "R4 readout lane vs model", lane(c), m_res[c]);
            end
        end
    end

    task automatic strobe(int d);
        @(negedge clk);
        conv_done = 1'b1;
        conv_data = DATA_W'(d);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seed = seed * 32'd1664525 + 32'd1013904223;
            conv_done = seed[30] | seed[29];
            conv_data = seed[21:8];
        end
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic set_cfg(int n, int x);
        @(negedge clk);
        cfg_nch  = 5'(n);
        cfg_segs = 3'(x);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_nch = 5'd16; cfg_segs = 3'd3;
        conv_done = 1'b0; conv_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mux_sel == 0, "R1 reset select", int'(mux_sel), 0);
        chk(sum_valid == 0, "R1 reset valid", int'(sum_valid), 0);
        chk(sum_flat == 0, "R1 reset lanes", lane(0), 0);
        rst = 1'b0;
        cmp_en = 1;

        // R2: 16 channels, X=3 -> L=16
        repeat (15) strobe(3);
        chk(mux_sel == 15, "R2 last channel with N=16 X=3", int'(mux_sel), 15);
        strobe(3);
        chk(mux_sel == 0, "R3 wrap after 16", int'(mux_sel), 0);
        run(400);

        // R6: config change with a pulse in the same cycle
        @(negedge clk);
        cfg_nch = 5'd15; conv_done = 1'b1; conv_data = 14'sd100;
        @(negedge clk);
        conv_done = 1'b0;
        chk(mux_sel == 0, "R6 select restarts", int'(mux_sel), 0);
        chk(sum_valid == 0, "R6 flags cleared", int'(sum_valid), 0);
        chk(sum_flat == 0, "R6 lanes cleared", lane(0), 0);

        // R2: 15 channels, X=3 -> L=13
        repeat (12) strobe(5);
        chk(mux_sel == 12, "R2 last channel with N=15 X=3", int'(mux_sel), 12);
        strobe(5);
        chk(mux_sel == 0, "R2 wrap at 13", int'(mux_sel), 0);
        run(400);

        // R2: even X=4 acts as 5, N=10 -> L=6
        set_cfg(10, 4);
        repeat (5) strobe(1);
        chk(mux_sel == 5, "R2 last channel with N=10 X=4", int'(mux_sel), 5);
        strobe(1);
        chk(mux_sel == 0, "R2 wrap at 6", int'(mux_sel), 0);
        run(300);

        // R7: signed sums on a single-channel scan, X=3
        set_cfg(1, 3);
        repeat (3) strobe(-8192);
        chk(sum_valid[0] == 1'b1, "R7 flag after three negatives", int'(sum_valid[0]), 1);
        chk(lane(0) == -24576, "R7 negative full-scale sum", lane(0), -24576);
        repeat (2) strobe(8191);
        chk(lane(0) == -24576, "R5 lane holds mid-collection", lane(0), -24576);
        strobe(8191);
        chk(lane(0) == 24573, "R7 positive full-scale sum", lane(0), 24573);

        // R2: X=0 acts as 1, N=5 -> L=5; every pulse completes
        set_cfg(5, 0);
        strobe(-7);
        chk(lane(0) == -7, "R5 single-segment completion", lane(0), -7);
        chk(mux_sel == 1, "R3 advance after one pulse", int'(mux_sel), 1);
        run(200);

        // R2: N=0 read as 1, X=7
        set_cfg(0, 7);
        run(200);

        // R2: N=31 clamps to 16, X=5 -> L=16
        set_cfg(31, 5);
        run(400);

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule